// File: doc/BRIEF.md
# Multi-mode addressable bit latch

This block keeps a small bank of single-bit storage cells that share one data input. A binary select chooses which cell a write lands on. Two active-low controls pick the operating mode:

- **Write:** one addressed bit is written.
- **Hold:** every bit holds its value.
- **Demultiplex:** the data level is routed to one output and all the others are forced low.
- **Clear:** every output is low.

In write mode, stepping the select once per cycle with new data shifts a serial stream into a parallel word. The same storage, with clear held active, serves as a one-hot decoder with active-high outputs.

Writes are taken on the rising clock edge, so the storage is a clocked equivalent of a level-sensitive latch array. The clear control empties the storage at once, without waiting for an edge. The outputs of the demultiplex and clear modes follow the inputs combinationally.

Several instances can be cascaded into a wider register or decoder. An external decode of the upper address bits drives each instance's enable. An optional guard raises a one-cycle flag when the select moves between two consecutive edges while the enable is held active. That situation risks writing the wrong bit.

Top module: `addr_bit_latch`

## Requirements
- R1: With clear inactive (clr_ni=1) and enable active (en_ni=0), the rising edge loads din_i into output bit q_o[addr_i]; every other output bit keeps its value.
- R2: With clear inactive and enable inactive (en_ni=1), no output bit changes across an edge, whatever addr_i and din_i are. This is the idle state used by a cascaded instance that is not selected.
- R3: With clear active (clr_ni=0) and enable active, q_o equals din_i placed at bit position addr_i, with all other bits low. The outputs follow the inputs without waiting for an edge.
- R4: With clear active and enable inactive, q_o is all zeros whatever addr_i and din_i are.
- R5: Driving clr_ni low empties the storage immediately, with no clock edge. After clr_ni returns high, q_o stays all zeros until a later write.
- R6: While reset is applied, and after it is released, q_o is all zeros and addr_change_err_o is 0.
- R7: addr_change_err_o is 1 for the cycle after edge k exactly when en_ni was 0 at edge k and at edge k-1 and addr_i differed between those two edges; otherwise it is 0.
- R8: Leaving the demultiplex mode (clear released with enable inactive) leaves all stored bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes take effect on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_ni | input | 1 | Active-low clear; empties storage asynchronously and selects the clear or demultiplex mode |
| en_ni | input | 1 | Active-low enable; selects the write or demultiplex mode and serves as the cascade select |
| addr_i | input | ADDR_W | Bit select, binary |
| din_i | input | 1 | Data input shared by all bits |
| q_o | output | NUM_BITS | Parallel outputs; bit i belongs to address i |
| addr_change_err_o | output | 1 | One-cycle flag: the select moved between consecutive edges while enabled |

## Verification
The bench builds the block at NUM_BITS=8, ADDR_W=3 and GUARD_EN=1. This is small enough to sweep every address with both data levels in each of the four modes. It also covers a full serial byte load in which every step after the first trips the guard. The clear test pulses clear low between two edges. This shows that the storage itself is emptied, separately from the output masking. With the guard built in, the flag is checked both for consecutive enabled steps and for address changes made while the enable is off.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } alat_mode_e;

endpackage

// File: rtl/alat_rst_sync.sv
module alat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/alat_mode_dec.sv
module alat_mode_dec
  import addr_latch_pkg::*;
(
  input  logic       clr_n,
  input  logic       en_n,
  output alat_mode_e mode,
  output logic       wr_en,
  output logic       dmx_en
);

  always_comb begin
    unique case ({clr_n, en_n})
      2'b10:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end

  assign wr_en  = (mode == MODE_WRITE);
  assign dmx_en = (mode == MODE_DEMUX);

endmodule

// File: rtl/alat_store.sv
module alat_store #(
  parameter int NUM_BITS = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                din,
  output logic [NUM_BITS-1:0] store_q
);

  for (genvar gi = 0; gi < NUM_BITS; gi++) begin : g_bit
    logic bit_we;
    logic bit_d;

    // next-state for one cell: clock enable only when this cell is addressed
    always_comb begin
      bit_we = wr_en && (addr == ADDR_W'(gi));
      bit_d  = din;
    end

    always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
      if (!rst_n) begin
        store_q[gi] <= 1'b0;
      end else if (!clr_n) begin
        store_q[gi] <= 1'b0;
      end else if (bit_we) begin
        store_q[gi] <= bit_d;
      end
    end
  end

endmodule

// File: rtl/alat_out_mux.sv
module alat_out_mux #(
  parameter int NUM_BITS = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                clr_n,
  input  logic                dmx_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                din,
  input  logic [NUM_BITS-1:0] store_q,
  output logic [NUM_BITS-1:0] q
);

  logic [NUM_BITS-1:0] dmx_vec;

  for (genvar gi = 0; gi < NUM_BITS; gi++) begin : g_dmx
    assign dmx_vec[gi] = dmx_en && din && (addr == ADDR_W'(gi));
  end

  always_comb begin
    if (clr_n) begin
      q = store_q;
    end else begin
      q = dmx_vec;
    end
  end

endmodule

// File: rtl/alat_addr_guard.sv
module alat_addr_guard #(
  parameter int ADDR_W   = 3,
  parameter bit GUARD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              err
);

  if (GUARD_EN) begin : g_guard
    logic              prev_act_q;
    logic [ADDR_W-1:0] prev_addr_q;
    logic              err_q;
    logic              err_d;

    always_comb begin
      err_d = !en_n && prev_act_q && (addr != prev_addr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_act_q  <= 1'b0;
        prev_addr_q <= '0;
        err_q       <= 1'b0;
      end else begin
        prev_act_q  <= !en_n;
        prev_addr_q <= addr;
        err_q       <= err_d;
      end
    end

    assign err = err_q;
  end else begin : g_noguard
    assign err = 1'b0;
  end

endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
  import addr_latch_pkg::*;
#(
  parameter int NUM_BITS = 8,
  parameter int ADDR_W   = $clog2(NUM_BITS),
  parameter bit GUARD_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_ni,
  input  logic                en_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                din_i,
  output logic [NUM_BITS-1:0] q_o,
  output logic                addr_change_err_o
);

  logic                rst_n_sync;
  alat_mode_e          mode;
  logic                wr_en;
  logic                dmx_en;
  logic [NUM_BITS-1:0] store_q;

  alat_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk_i),
    .rst_n_async (rst_ni),
    .rst_n_sync  (rst_n_sync)
  );

  alat_mode_dec u_mode (
    .clr_n  (clr_ni),
    .en_n   (en_ni),
    .mode   (mode),
    .wr_en  (wr_en),
    .dmx_en (dmx_en)
  );

  alat_store #(.NUM_BITS(NUM_BITS), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk_i),
    .rst_n   (rst_n_sync),
    .clr_n   (clr_ni),
    .wr_en   (wr_en),
    .addr    (addr_i),
    .din     (din_i),
    .store_q (store_q)
  );

  alat_out_mux #(.NUM_BITS(NUM_BITS), .ADDR_W(ADDR_W)) u_out (
    .clr_n   (clr_ni),
    .dmx_en  (dmx_en),
    .addr    (addr_i),
    .din     (din_i),
    .store_q (store_q),
    .q       (q_o)
  );

  alat_addr_guard #(.ADDR_W(ADDR_W), .GUARD_EN(GUARD_EN)) u_guard (
    .clk   (clk_i),
    .rst_n (rst_n_sync),
    .en_n  (en_ni),
    .addr  (addr_i),
    .err   (addr_change_err_o)
  );

endmodule

// File: rtl/alat_checker.sv
module alat_checker #(
  parameter int NUM_BITS = 8,
  parameter int ADDR_W   = 3,
  parameter bit GUARD_EN = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr_n,
  input logic                en_n,
  input logic [ADDR_W-1:0]   addr,
  input logic                din,
  input logic [NUM_BITS-1:0] q,
  input logic                err
);

  // set when clear went low since the last edge, so edge-to-edge checks skip it
  logic clr_hit;
  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n) begin
      clr_hit <= 1'b0;
    end else if (!clr_n) begin
      clr_hit <= 1'b1;
    end else begin
      clr_hit <= 1'b0;
    end
  end

  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n || clr_hit)
    (clr_n && !en_n) |=> (!clr_n || q[$past(addr)] == $past(din)));

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n || clr_hit)
    (clr_n && en_n) |=> (!clr_n || q == $past(q)));

  a_r3_demux_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !en_n) |-> ($onehot0(q) && ((|q) == din)));

  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && en_n) |-> (q == '0));

  if (GUARD_EN) begin : g_err_chk
    a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ($past(!en_n) && $past(!en_n, 2) && ($past(addr) != $past(addr, 2))));
  end else begin : g_err_off
    a_r7_err_off: assert property (@(posedge clk) disable iff (!rst_n) !err);
  end

endmodule

bind addr_bit_latch alat_checker #(
  .NUM_BITS (NUM_BITS),
  .ADDR_W   (ADDR_W),
  .GUARD_EN (GUARD_EN)
) u_chk (
  .clk   (clk_i),
  .rst_n (rst_n_sync),
  .clr_n (clr_ni),
  .en_n  (en_ni),
  .addr  (addr_i),
  .din   (din_i),
  .q     (q_o),
  .err   (addr_change_err_o)
);

// File: tb/addr_bit_latch_tb.sv
module addr_bit_latch_tb;

  localparam int NB = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr_n;
  logic          en_n;
  logic [AW-1:0] addr;
  logic          din;
  logic [NB-1:0] q;
  logic          err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model
  logic [NB-1:0] m_store = '0;
  logic          m_err   = 1'b0;
  logic          m_pen   = 1'b0;
  logic [AW-1:0] m_paddr = '0;

  always #5 clk = ~clk;

  addr_bit_latch #(.NUM_BITS(NB), .ADDR_W(AW), .GUARD_EN(1'b1)) u_dut (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .clr_ni            (clr_n),
    .en_ni             (en_n),
    .addr_i            (addr),
    .din_i             (din),
    .q_o               (q),
    .addr_change_err_o (err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] exp_q();
    if (clr_n) return m_store;
    if (!en_n && din) return NB'(1) << addr;
    return '0;
  endfunction

  // drive inputs, take one edge, update model, check outputs 2 ns after the edge
  task automatic step(input string req, input logic c, input logic e,
                      input logic [AW-1:0] a, input logic d);
    clr_n = c; en_n = e; addr = a; din = d;
    @(posedge clk);
    #2;
    if (!c) m_store = '0;
    else if (!e) m_store[a] = d;
    m_err   = !e && m_pen && (a != m_paddr);
    m_pen   = !e;
    m_paddr = a;
    chk(req, 32'(q), 32'(exp_q()));
    chk({req, " err"}, 32'(err), 32'(m_err));
  endtask

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; en_n = 1'b1; addr = '0; din = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R6 q in reset", 32'(q), 0);
    chk("R6 err in reset", 32'(err), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R6 q after reset", 32'(q), 0);
    chk("R6 err after reset", 32'(err), 0);

    // R1 / R7: serial load of a byte, one bit per cycle, enable held active
    for (int i = 0; i < NB; i++) step("R1 serial load", 1'b1, 1'b0, AW'(i), 1'(8'hA5 >> i));
    chk("R1 serial byte", 32'(q), 32'h0A5);
    step("R2 idle after load", 1'b1, 1'b1, '0, 1'b0);

    // R2: hold sweep over every address and data level
    for (int a = 0; a < NB; a++)
      for (int d = 0; d < 2; d++) step("R2 hold", 1'b1, 1'b1, AW'(a), 1'(d));

    // R1 / R7: single writes with the enable released while the address moves
    for (int a = 0; a < NB; a++) begin
      for (int d = 0; d < 2; d++) begin
        step("R1 single write", 1'b1, 1'b0, AW'(a), 1'(d ^ (a & 1)));
        step("R7 same addr again", 1'b1, 1'b0, AW'(a), 1'(d ^ (a & 1)));
        step("R7 addr moved while idle", 1'b1, 1'b1, AW'(NB - 1 - a), 1'b1);
      end
    end
    // R7: two consecutive enabled steps to different addresses
    step("R7 first", 1'b1, 1'b0, 3'd2, 1'b1);
    step("R7 second", 1'b1, 1'b0, 3'd5, 1'b1);
    chk("R7 flag raised", 32'(err), 1);
    step("R7 flag drops", 1'b1, 1'b1, 3'd5, 1'b0);
    chk("R7 flag one cycle", 32'(err), 0);

    // R3: demultiplex sweep
    for (int a = 0; a < NB; a++)
      for (int d = 0; d < 2; d++) step("R3 demux", 1'b0, 1'b0, AW'(a), 1'(d));
    // R8: leaving demux through clear-with-hold then hold
    step("R4 clear after demux", 1'b0, 1'b1, 3'd3, 1'b1);
    step("R8 stored zero after demux", 1'b1, 1'b1, 3'd3, 1'b1);
    chk("R8 zero word", 32'(q), 0);

    // R4: load a pattern, then clear sweep
    for (int i = 0; i < NB; i++) step("R1 reload", 1'b1, 1'b0, AW'(i), 1'(8'h3C >> i));
    for (int a = 0; a < NB; a++)
      for (int d = 0; d < 2; d++) step("R4 clear", 1'b0, 1'b1, AW'(a), 1'(d));

    // R5: asynchronous clear pulse between two edges
    for (int i = 0; i < NB; i++) step("R1 fill ones", 1'b1, 1'b0, AW'(i), 1'b1);
    step("R2 idle ones", 1'b1, 1'b1, '0, 1'b0);
    chk("R5 precondition", 32'(q), 32'hFF);
    clr_n = 1'b0;
    #1;
    chk("R5 outputs low without edge", 32'(q), 0);
    clr_n = 1'b1;
    #1;
    chk("R5 storage emptied without edge", 32'(q), 0);
    m_store = '0;
    step("R5 stays empty", 1'b1, 1'b1, 3'd4, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule